// File: doc/BRIEF.md
# Memory-Reference Effective Address Generator

This block produces the data address for a 16-bit memory-reference instruction on a stack machine. A start pulse captures the instruction word together with the current program counter, data base, frame marker, stack pointer and index register.

The low ten bits of the instruction hold a mode prefix of variable length. The prefix picks one of four bases and says whether the displacement is added to it or subtracted from it. The displacement takes whatever bits the prefix leaves, so its width depends on the mode.

When the indirect flag is set, the block makes one read through a synchronous data-memory port. The word it reads, taken relative to the data base, becomes the new address. When the index flag is set, the index value is added last, after any indirection. The result comes out with a one-cycle done strobe.

Top module: `mref_addr_gen`

## Requirements
- R1: With instruction bits 9-8 equal to 00, the direct address is PC plus the unsigned 8-bit displacement in bits 7-0.
- R2: With bits 9-8 equal to 01, the direct address is PC minus the 8-bit displacement in bits 7-0.
- R3: With bits 9-8 equal to 10, the direct address is DB plus the 8-bit displacement in bits 7-0.
- R4: With bits 9-7 equal to 110, the direct address is Q plus the 7-bit displacement in bits 6-0.
- R5: With bits 9-6 equal to 1110, the direct address is Q minus the 6-bit displacement in bits 5-0.
- R6: With bits 9-6 equal to 1111, the direct address is SP minus the 6-bit displacement in bits 5-0.
- R7: All address sums and differences wrap modulo 2^16.
- R8: When bit 10 (indirect) is set, the block asserts mem_rd_en for exactly one cycle with mem_addr equal to the direct address. The final address is then DB plus the word returned on mem_rdata one cycle after the read. When bit 10 is clear, no read is made.
- R9: When bit 11 (index) is set, the index value is added to the final address, after any indirection.
- R10: done is high for exactly one cycle, with the address on ea. For a direct reference this is the second rising edge after the edge that samples start. For an indirect reference it is the third.
- R11: A start that arrives while an operation is in progress is ignored. It does not change the result, and it produces no extra done.
- R12: After reset, done and mem_rd_en are low.
- R13: Instruction bits 15-12 (the opcode) have no effect on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and begin (ignored when busy) |
| instr | input | 16 | Memory-reference instruction word |
| pc_val | input | 16 | Program counter |
| db_val | input | 16 | Data base |
| q_val | input | 16 | Stack frame marker |
| sp_val | input | 16 | Stack pointer |
| x_val | input | 16 | Index register |
| mem_rd_en | output | 1 | Indirect read request |
| mem_addr | output | 16 | Indirect read address |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd_en |
| done | output | 1 | One-cycle strobe with the final address |
| ea | output | 16 | Final effective address |

## Verification
The case that is hardest to reach from the ports is a second start arriving while an indirect operation is still in flight. It must neither disturb the captured inputs nor add a strobe. The bench pulses start with a different instruction and register set in the cycle the read is issued. It then checks that the result matches the first operation and that no further done follows. Wraparound is forced with displacements larger than a small base and with bases near the top of the range. Random instructions cover every prefix, both flags and arbitrary opcode bits.

// File: rtl/mref_addr_gen.sv
module mref_addr_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [15:0]  instr,
  input  logic [W-1:0] pc_val,
  input  logic [W-1:0] db_val,
  input  logic [W-1:0] q_val,
  input  logic [W-1:0] sp_val,
  input  logic [W-1:0] x_val,
  output logic         mem_rd_en,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic         done,
  output logic [W-1:0] ea
);
  typedef enum logic [1:0] {S_IDLE, S_CALC, S_WAIT} state_t;
  state_t st;

  logic [15:0]  ir;
  logic [W-1:0] pc_r, db_r, q_r, sp_r, x_r;
  logic [W-1:0] direct, post;

  wire accept = start && st == S_IDLE;
  wire ind    = ir[10];
  assign post = ir[11] ? x_r : '0;

  always_comb begin
    casez (ir[9:6])
      4'b00??: direct = pc_r + {{(W-8){1'b0}}, ir[7:0]};
      4'b01??: direct = pc_r - {{(W-8){1'b0}}, ir[7:0]};
      4'b10??: direct = db_r + {{(W-8){1'b0}}, ir[7:0]};
      4'b110?: direct = q_r  + {{(W-7){1'b0}}, ir[6:0]};
      4'b1110: direct = q_r  - {{(W-6){1'b0}}, ir[5:0]};
      default: direct = sp_r - {{(W-6){1'b0}}, ir[5:0]};
    endcase
  end

  assign mem_rd_en = st == S_CALC && ind;
  assign mem_addr  = direct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; ea <= '0; ir <= '0;
      pc_r <= '0; db_r <= '0; q_r <= '0; sp_r <= '0; x_r <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          ir <= instr; pc_r <= pc_val; db_r <= db_val;
          q_r <= q_val; sp_r <= sp_val; x_r <= x_val;
          st <= S_CALC;
        end
        S_CALC: if (ind) st <= S_WAIT;
        else begin
          ea <= direct + post; done <= 1'b1; st <= S_IDLE;
        end
        default: begin
          ea <= db_r + mem_rdata + post; done <= 1'b1; st <= S_IDLE;
        end
      endcase
    end
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_no_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done);
  a_r8_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  a_r8_read_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ##2 done);
  a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != S_IDLE) |=> $stable(ir) && $stable(db_r) && $stable(x_r));
  a_r8_no_read_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd_en);
endmodule

// File: tb/mref_addr_gen_tb.sv
module mref_addr_gen_tb_top;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] instr = 0, pc_val = 0, db_val = 0, q_val = 0, sp_val = 0, x_val = 0;
  logic [15:0] mem_rdata = 0, mem_addr, ea;
  logic mem_rd_en, done;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  mref_addr_gen dut_i (.clk, .rst_n, .start, .instr, .pc_val, .db_val, .q_val,
    .sp_val, .x_val, .mem_rd_en, .mem_addr, .mem_rdata, .done, .ea);

  function automatic logic [15:0] mem_word(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC35A;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(mem_addr);

  function automatic logic [15:0] direct_fn(logic [15:0] i, logic [15:0] pc,
      logic [15:0] db, logic [15:0] q, logic [15:0] sp);
    if (i[9:8] == 2'b00) return pc + 16'(i[7:0]);
    if (i[9:8] == 2'b01) return pc - 16'(i[7:0]);
    if (i[9:8] == 2'b10) return db + 16'(i[7:0]);
    if (i[9:7] == 3'b110) return q + 16'(i[6:0]);
    if (i[9:6] == 4'b1110) return q - 16'(i[5:0]);
    return sp - 16'(i[5:0]);
  endfunction

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [15:0] i, logic [15:0] pc, logic [15:0] db,
      logic [15:0] q, logic [15:0] sp, logic [15:0] x, bit poke);
    logic [15:0] d, f;
    int n, lat, reads;
    d = direct_fn(i, pc, db, q, sp);
    f = (i[10] ? db + mem_word(d) : d) + (i[11] ? x : 16'h0);
    lat = i[10] ? 3 : 2;
    @(negedge clk);
    instr = i; pc_val = pc; db_val = db; q_val = q; sp_val = sp; x_val = x; start = 1;
    @(negedge clk); start = 0;
    n = 1; reads = 0;
    while (!done && n < 10) begin
      if (mem_rd_en) begin
        reads++;
        chk(mem_addr == d, "R8 read address", mem_addr, d);
      end
      if (poke && n == 1) begin
        instr = ~i; db_val = ~db; x_val = x + 16'h1111; pc_val = ~pc; start = 1;
      end
      @(negedge clk); start = 0; n++;
    end
    chk(done == 1, "R10 done seen", 16'(done), 16'h1);
    chk(n == lat, "R10 latency", 16'(n), 16'(lat));
    chk(ea == f, req, ea, f);
    chk(reads == (i[10] ? 1 : 0), "R8 read count", 16'(reads), 16'(i[10]));
    @(negedge clk);
    chk(!done, "R10 single-cycle done", 16'(done), 16'h0);
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        chk(!done, "R11 no extra done", 16'(done), 16'h0);
      end
    end
  endtask

  initial begin
    fork
      begin
        #5;
        chk(!done && !mem_rd_en, "R12 reset state", {14'h0, done, mem_rd_en}, 16'h0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        run("R1 PC plus",  16'h00FF, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h5, 0);
        run("R2 PC minus", 16'h01FF, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h5, 0);
        run("R3 DB plus",  16'h0280, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h5, 0);
        run("R4 Q plus",   16'h037F, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h5, 0);
        run("R5 Q minus",  16'h03BF, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h5, 0);
        run("R6 SP minus", 16'h03FF, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h5, 0);
        run("R7 wrap minus", 16'h01FF, 16'h0010, 16'h0, 16'h0, 16'h0, 16'h0, 0);
        run("R7 wrap plus", 16'h08FF, 16'hFFF0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 0);
        run("R8 indirect", 16'h0412, 16'h1234, 16'h8000, 16'h0, 16'h0, 16'h0, 0);
        run("R9 post-index", 16'h0C12, 16'h1234, 16'h8000, 16'h0, 16'h0, 16'h0101, 0);
        run("R13 opcode 0", 16'h03C7, 16'h0, 16'h0, 16'h0, 16'h0777, 16'h0, 0);
        run("R13 opcode F", 16'hF3C7, 16'h0, 16'h0, 16'h0, 16'h0777, 16'h0, 0);
        run("R11 busy ignore", 16'h0E85, 16'h0, 16'h4000, 16'h6000, 16'h0, 16'h22, 1);
        run("R11 busy ignore direct", 16'h0305, 16'h0, 16'h4000, 16'h6000, 16'h0, 16'h22, 1);
        void'($urandom(32'd7321));
        for (int k = 0; k < 300; k++)
          run("R1-6 random", 16'($urandom), 16'($urandom), 16'($urandom),
              16'($urandom), 16'($urandom), 16'($urandom), ($urandom % 8) == 0);
      end
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 16'h0, 16'h1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule